// File: doc/BRIEF.md
# Load Data Alignment Network

This combinational block sits on the read path between a memory data port and the processor. The processor address is split in two. The word address goes to memory. The byte number within the word goes to this block, together with an access size and the full word that memory returns. The block steers the requested byte, halfword or word into the least significant lanes of the value handed back to the processor. For byte and halfword loads it fills the unused upper lanes with zeros or with copies of the loaded value's top bit, as a signed-load input selects.

A small control function turns the byte number and the access size into one select per output lane, a fill flag per lane and the lane that supplies the sign bit. The block does not use a barrel shift. The same function raises a trouble flag when the request cannot be served from the single word on the port. This happens for a halfword that crosses a word boundary, a word that is not word-aligned, or a size code that is reserved. While trouble is raised, the data output carries no meaning.

Memory byte lane 0 holds the least significant byte of the word: lane k is bits 8k+7 down to 8k.

Top module: `ldalign_top`

## Requirements
- R1: For a byte load (size code 0), bits 7:0 of the output equal memory byte lane `byte_ofs_i`.
- R2: For an unsigned byte load (`signed_i` = 0), output bits 31:8 are zero.
- R3: For a signed byte load (`signed_i` = 1), output bits 31:8 all equal output bit 7.
- R4: For a halfword load (size code 1) at an even byte number, bits 15:0 of the output equal lanes `byte_ofs_i` (low) and `byte_ofs_i`+1 (high). Bits 31:16 are zero when unsigned and copies of bit 15 when signed.
- R5: For a word load (size code 2) at byte number 0, the output equals the memory word whatever `signed_i` is, and trouble is low.
- R6: A halfword load at an odd byte number raises `trouble_o`.
- R7: A word load at any nonzero byte number raises `trouble_o`.
- R8: Size code 3 is reserved and always raises `trouble_o`.
- R9: A byte load never raises `trouble_o`, at any byte number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_ofs_i | input | 2 | Byte number within the memory word |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| signed_i | input | 1 | 1 sign-extends byte and halfword loads, 0 zero-fills them |
| mem_word_i | input | 32 | Word read from memory, lane 0 least significant |
| load_data_o | output | 32 | Aligned and extended value for the processor |
| trouble_o | output | 1 | Request cannot be served in one memory cycle |

## Verification
The checks on the data output assume that the inputs are settled and that trouble is low. Every data property is therefore guarded by the legal size and byte number it describes, and the trouble properties depend on the size and byte number alone. The stimulus changes all inputs together once per cycle, well away from the sampling point. It sweeps every byte number, every size code and both fill modes over word patterns that put set and clear top bits in every lane. On trouble cycles the bench checks only the trouble flag and never compares the data.

// File: rtl/ldalign_pkg.sv
package ldalign_pkg;

  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

endpackage

// File: rtl/ldalign_ctrl.sv
module ldalign_ctrl #(
  parameter int LANES = 4,
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0]             ofs_i,
  input  logic [1:0]                   size_i,
  input  logic                         sgn_i,
  output logic [LANES-1:0][OFS_W-1:0]  sel_o,
  output logic [LANES-1:0]             fill_o,
  output logic [OFS_W-1:0]             msb_lane_o,
  output logic                         ext_en_o,
  output logic                         trouble_o
);

  localparam int MAX_SZ = $clog2(LANES);

  // Number of bytes an access of size code sz spans
  function automatic logic [OFS_W:0] bytes_of(input logic [1:0] sz);
    if (int'(sz) > MAX_SZ) return (OFS_W+1)'(LANES);
    return (OFS_W+1)'(1) << sz;
  endfunction

  // Byte number not a multiple of the access size
  function automatic logic off_bad(input logic [OFS_W-1:0] o, input logic [1:0] sz);
    logic [OFS_W:0] m;
    m = bytes_of(sz) - (OFS_W+1)'(1);
    return ({1'b0, o} & m) != '0;
  endfunction

  logic [OFS_W:0] nbytes;
  logic           size_rsvd;

  assign nbytes     = bytes_of(size_i);
  assign size_rsvd  = int'(size_i) > MAX_SZ;
  assign trouble_o  = size_rsvd | off_bad(ofs_i, size_i);
  assign msb_lane_o = ofs_i + OFS_W'(nbytes - (OFS_W+1)'(1));
  assign ext_en_o   = sgn_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane_ctl
    assign sel_o[k]  = ofs_i + OFS_W'(k);
    assign fill_o[k] = (OFS_W+1)'(k) >= nbytes;
  end

endmodule

// File: rtl/ldalign_ext.sv
module ldalign_ext #(
  parameter int LANES  = 4,
  parameter int OFS_W  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0][LANE_W-1:0] mem_i,
  input  logic [OFS_W-1:0]             msb_lane_i,
  input  logic                         ext_en_i,
  output logic                         fill_bit_o
);

  assign fill_bit_o = ext_en_i & mem_i[msb_lane_i][LANE_W-1];

endmodule

// File: rtl/ldalign_lane.sv
module ldalign_lane #(
  parameter int LANES  = 4,
  parameter int OFS_W  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0][LANE_W-1:0] mem_i,
  input  logic [OFS_W-1:0]             sel_i,
  input  logic                         fill_i,
  input  logic                         fill_bit_i,
  output logic [LANE_W-1:0]            lane_o
);

  assign lane_o = fill_i ? {LANE_W{fill_bit_i}} : mem_i[sel_i];

endmodule

// File: rtl/ldalign_top.sv
module ldalign_top
  import ldalign_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] byte_ofs_i,
  input  logic [1:0]                  size_i,
  input  logic                        signed_i,
  input  logic [DATA_W-1:0]           mem_word_i,
  output logic [DATA_W-1:0]           load_data_o,
  output logic                        trouble_o
);

  localparam int LANES = DATA_W / LANE_W;
  localparam int OFS_W = $clog2(LANES);

  logic [LANES-1:0][LANE_W-1:0] mem_lanes;
  logic [LANES-1:0][LANE_W-1:0] out_lanes;
  logic [LANES-1:0][OFS_W-1:0]  lane_sel;
  logic [LANES-1:0]             lane_fill;
  logic [OFS_W-1:0]             msb_lane;
  logic                         ext_en;
  logic                         fill_bit;

  assign mem_lanes   = mem_word_i;
  assign load_data_o = out_lanes;

  ldalign_ctrl #(.LANES(LANES), .OFS_W(OFS_W)) u_ctrl (
    .ofs_i      (byte_ofs_i),
    .size_i     (size_i),
    .sgn_i      (signed_i),
    .sel_o      (lane_sel),
    .fill_o     (lane_fill),
    .msb_lane_o (msb_lane),
    .ext_en_o   (ext_en),
    .trouble_o  (trouble_o)
  );

  ldalign_ext #(.LANES(LANES), .OFS_W(OFS_W), .LANE_W(LANE_W)) u_ext (
    .mem_i      (mem_lanes),
    .msb_lane_i (msb_lane),
    .ext_en_i   (ext_en),
    .fill_bit_o (fill_bit)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ldalign_lane #(.LANES(LANES), .OFS_W(OFS_W), .LANE_W(LANE_W)) u_lane (
      .mem_i      (mem_lanes),
      .sel_i      (lane_sel[k]),
      .fill_i     (lane_fill[k]),
      .fill_bit_i (fill_bit),
      .lane_o     (out_lanes[k])
    );
  end

endmodule

// File: rtl/ldalign_chk.sv
module ldalign_chk #(
  parameter int DATA_W = 32
) (
  input logic [$clog2(DATA_W/8)-1:0] byte_ofs_i,
  input logic [1:0]                  size_i,
  input logic                        signed_i,
  input logic [DATA_W-1:0]           mem_word_i,
  input logic [DATA_W-1:0]           load_data_o,
  input logic                        trouble_o
);

  always_comb begin
    if (size_i == 2'd0) begin
      p_byte_no_trouble_r9: assert (!trouble_o) else $error("byte load flagged trouble");
      p_byte_lane_r1: assert (load_data_o[7:0] == 8'(mem_word_i >> (8 * byte_ofs_i)))
        else $error("byte lane wrong");
      if (!signed_i) begin
        p_byte_zero_fill_r2: assert (load_data_o[DATA_W-1:8] == '0) else $error("zero fill wrong");
      end else begin
        p_byte_sign_fill_r3: assert (load_data_o[DATA_W-1:8] == {(DATA_W-8){load_data_o[7]}})
          else $error("sign fill wrong");
      end
    end
    if (size_i == 2'd1 && byte_ofs_i[0]) begin
      p_half_odd_trouble_r6: assert (trouble_o) else $error("odd halfword not flagged");
    end
    if (size_i == 2'd1 && !byte_ofs_i[0] && !trouble_o) begin
      p_half_lanes_r4: assert (load_data_o[15:0] == 16'(mem_word_i >> (8 * byte_ofs_i)))
        else $error("halfword lanes wrong");
    end
    if (size_i == 2'd2 && byte_ofs_i != '0) begin
      p_word_misalign_r7: assert (trouble_o) else $error("misaligned word not flagged");
    end
    if (size_i == 2'd2 && byte_ofs_i == '0) begin
      p_word_pass_r5: assert (!trouble_o && load_data_o == mem_word_i) else $error("word pass wrong");
    end
    if (size_i == 2'd3) begin
      p_rsvd_trouble_r8: assert (trouble_o) else $error("reserved size not flagged");
    end
  end

endmodule

bind ldalign_top ldalign_chk #(.DATA_W(DATA_W)) u_chk (
  .byte_ofs_i  (byte_ofs_i),
  .size_i      (size_i),
  .signed_i    (signed_i),
  .mem_word_i  (mem_word_i),
  .load_data_o (load_data_o),
  .trouble_o   (trouble_o)
);

// File: tb/tb_ldalign_top.sv
module tb_ldalign_top;

  typedef struct {
    logic [1:0]  ofs;
    logic [1:0]  sz;
    logic        sg;
    logic [31:0] mem;
    logic [31:0] exp_d;
    logic        exp_t;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  byte_ofs;
  logic [1:0]  size;
  logic        sgn;
  logic [31:0] mem_word;
  logic [31:0] load_data;
  logic        trouble;

  int n_checks = 0;
  int n_fails  = 0;
  bit drv_done = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  ldalign_top dut (
    .byte_ofs_i  (byte_ofs),
    .size_i      (size),
    .signed_i    (sgn),
    .mem_word_i  (mem_word),
    .load_data_o (load_data),
    .trouble_o   (trouble)
  );

  // Reference: shift the word down, mask to the access width, then extend
  function automatic void ref_model(input logic [1:0] o, input logic [1:0] s, input logic g,
                                    input logic [31:0] m, output logic [31:0] d, output logic t);
    int nb;
    logic [31:0] mask;
    logic [31:0] v;
    nb = 1 << s;
    t  = (s == 2'd3) || ((int'(o) % nb) != 0);
    v  = m >> (8 * o);
    mask = (nb >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 32'd1);
    v = v & mask;
    if (g && nb < 4 && v[8*nb-1]) v = v | ~mask;
    d = v;
  endfunction

  function automatic string data_tag(input logic [1:0] s, input logic g);
    case (s)
      2'd0:    return g ? "R1 R3" : "R1 R2";
      2'd1:    return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string trb_tag(input logic [1:0] s);
    case (s)
      2'd0:    return "R9";
      2'd1:    return "R6";
      2'd2:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [1:0] o, input logic [1:0] s, input logic g, input logic [31:0] m);
    item_t it;
    @(posedge clk);
    #1;
    byte_ofs = o; size = s; sgn = g; mem_word = m;
    it.ofs = o; it.sz = s; it.sg = g; it.mem = m;
    ref_model(o, s, g, m, it.exp_d, it.exp_t);
    q.push_back(it);
  endtask

  // Monitor: samples at the falling edge, away from the driving point
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_checks++;
      if (trouble !== it.exp_t) begin
        n_fails++;
        $display("FAIL %s trouble ofs=%0d size=%0d: actual %b expected %b",
                 trb_tag(it.sz), it.ofs, it.sz, trouble, it.exp_t);
      end
      if (!it.exp_t) begin
        n_checks++;
        if (load_data !== it.exp_d) begin
          n_fails++;
          $display("FAIL %s data ofs=%0d size=%0d sgn=%0d mem=%h: actual %h expected %h",
                   data_tag(it.sz, it.sg), it.ofs, it.sz, it.sg, it.mem, load_data, it.exp_d);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    logic [31:0] pats [6];
    pats = '{32'h80FF_7F01, 32'h1234_5678, 32'hFEDC_BA98,
             32'h0000_0000, 32'hFFFF_FFFF, 32'h7F80_017F};
    byte_ofs = '0; size = '0; sgn = 1'b0; mem_word = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-state check: all-zero inputs give a zero byte load, no trouble
    drive(2'd0, 2'd0, 1'b0, 32'h0);
    for (int p = 0; p < 6; p++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++)
          for (int g = 0; g < 2; g++)
            drive(2'(o), 2'(s), 1'(g), pats[p]);
    // Boundary: signed halfword at top lanes with set sign bit (R4)
    drive(2'd2, 2'd1, 1'b1, 32'h8001_0000);
    // Boundary: signed byte in lane 3 with sign clear (R3)
    drive(2'd3, 2'd0, 1'b1, 32'h7FFF_FFFF);
    repeat (3) @(posedge clk);
    drv_done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!drv_done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule